// File: doc/BRIEF.md
# Command-Driven SPI Sequencer Register Front End

This block is the software-facing register file for a command-driven SPI sequencer. A host reaches it through a simple strobe interface with separate read and write ports and a byte address that is decoded per 32-bit word. It holds three queues: one for 16-bit commands, one for transmit bytes and one for receive bytes. The host fills the first two and drains the third. The sequencer side takes commands and transmit bytes from queue heads and pushes received bytes.

Software can read a version word and hold the sequencer in reset through a soft-reset register. It can also read back the identifier of the most recent sync event. Three status registers report the free space in the command and transmit queues and the fill level of the receive queue. One level interrupt output combines four pending sources under an enable mask. Three sources are queue watermarks and the fourth is a sync-completion pulse from the sequencer.

The receive queue has two read ports. One returns the head byte and removes it. The other returns the head byte and leaves the queue unchanged.

Top module: `spi_seq_csr`

## Requirements
- R1: After `rst`, the soft-reset register (0x40) reads 1, the interrupt enable register (0x80) reads 0, `irq` is 0 and `rd_data` is 0.
- R2: A read of 0x00 returns the version word, laid out as {8'h00, major, minor, patch}. The major field in bits [23:16] is 1, and the default word is 0x00010061.
- R3: While bit 0 of the soft-reset register is 1, `engine_rst` is high, all three queues are emptied and held empty, and pushes from both sides are dropped. Writing 0 releases the reset.
- R4: A write to 0xE0 pushes `wr_data[15:0]` into the command queue. The sequencer receives commands in write order on `cmd_data` while `cmd_valid` is high, and takes each one with `cmd_rd`. A read of 0xD0 returns the command-queue depth minus its fill.
- R5: A write to 0xE4 pushes `wr_data[7:0]` into the transmit queue, which the sequencer pops with `tx_rd`. A read of 0xD4 returns the free space in the transmit queue.
- R6: A pulse on `rx_wr` pushes `rx_data` into the receive queue, and a read of 0xD8 returns its fill level. A read of 0xEC returns the head byte without removing it. A read of 0xE8 returns the head byte and removes it.
- R7: A push into a full queue is dropped and leaves the queue contents unchanged. `rx_ready` is low while the receive queue is full.
- R8: A read of 0xE8 or 0xEC on an empty receive queue returns 0 and leaves the fill level unchanged.
- R9: The pending register (0x84) has three level-sensitive bits. Bit 0 is set while the command queue fill is at or below CMD_AE. Bit 1 is set while the transmit queue fill is at or below TX_AE. Bit 2 is set while the receive queue fill is at or above RX_AF. A clear of one of these bits does not take effect while its condition still holds.
- R10: A `sync_pulse` outside soft reset stores `sync_id` in the register at 0xC0 and sets pending bit 3. Bit 3 stays set until a write of 1 to that bit position at 0x84.
- R11: `irq` is high exactly when the bitwise AND of the pending bits and the enable bits (0x80, bits [3:0]) is nonzero. It changes in the same cycle as the pending register.
- R12: `rd_data` holds the read result in the cycle after `rd_en` and is 0 in every other cycle. Reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | ADDR_W | Host write byte address |
| wr_data | input | DATA_W | Host write data |
| rd_en | input | 1 | Host read strobe |
| rd_addr | input | ADDR_W | Host read byte address |
| rd_data | output | DATA_W | Read result, valid the cycle after rd_en |
| irq | output | 1 | Level interrupt |
| engine_rst | output | 1 | Soft reset to the sequencer |
| cmd_rd | input | 1 | Sequencer takes the command head |
| cmd_data | output | CMD_W | Command queue head |
| cmd_valid | output | 1 | Command queue not empty |
| tx_rd | input | 1 | Sequencer takes the transmit head |
| tx_data | output | TX_W | Transmit queue head |
| tx_valid | output | 1 | Transmit queue not empty |
| rx_wr | input | 1 | Sequencer pushes a received byte |
| rx_data | input | RX_W | Received byte |
| rx_ready | output | 1 | Receive queue accepts a push |
| sync_pulse | input | 1 | Sync-completion event |
| sync_id | input | ID_W | Identifier carried by the sync event |

## Verification
The checks assume word-aligned host addresses, and they evaluate only the word index. The sequencer-side strobes are one-cycle pulses driven between clock edges. A pop on an empty queue or a push into a full one is allowed, because the queues ignore both. The bench drives every strobe for exactly one cycle from the falling edge and reads results one time unit after the rising edge. It keeps `sync_id` steady around each pulse. Overflow and empty-read cases are produced on purpose through the same strobes, so every stimulus stays inside the assumed input behaviour.

// File: rtl/spi_csr_pkg.sv
package spi_csr_pkg;

  localparam int IRQ_N       = 4;
  localparam int IRQ_CMD_LOW = 0;
  localparam int IRQ_TX_LOW  = 1;
  localparam int IRQ_RX_HIGH = 2;
  localparam int IRQ_SYNC    = 3;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_VERSION,
    SEL_SRST,
    SEL_IRQ_EN,
    SEL_IRQ_PEND,
    SEL_SYNC_ID,
    SEL_CMD_ROOM,
    SEL_TX_ROOM,
    SEL_RX_LEVEL,
    SEL_CMD_PUSH,
    SEL_TX_PUSH,
    SEL_RX_POP,
    SEL_RX_PEEK
  } csr_sel_e;

  // word index = byte address / 4
  function automatic csr_sel_e csr_decode(input logic [5:0] word);
    csr_sel_e s;
    case (word)
      6'h00:   s = SEL_VERSION;
      6'h10:   s = SEL_SRST;
      6'h20:   s = SEL_IRQ_EN;
      6'h21:   s = SEL_IRQ_PEND;
      6'h30:   s = SEL_SYNC_ID;
      6'h34:   s = SEL_CMD_ROOM;
      6'h35:   s = SEL_TX_ROOM;
      6'h36:   s = SEL_RX_LEVEL;
      6'h38:   s = SEL_CMD_PUSH;
      6'h39:   s = SEL_TX_PUSH;
      6'h3A:   s = SEL_RX_POP;
      6'h3B:   s = SEL_RX_PEEK;
      default: s = SEL_NONE;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/csr_fifo.sv
module csr_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          push_ok, pop_ok;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign push_ok = push && !full && !flush;
  assign pop_ok  = pop && !empty && !flush;
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push_ok) wp <= wp + 1'b1;
      if (pop_ok)  rp <= rp + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/csr_irq.sv
module csr_irq #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en_we,
  input  logic [N-1:0] en_wdata,
  input  logic         clr_we,
  input  logic [N-1:0] clr_mask,
  input  logic [N-1:0] cond,
  output logic [N-1:0] en,
  output logic [N-1:0] pend,
  output logic         irq
);

  logic [N-1:0] en_d, pend_d;

  always_comb begin
    en_d   = en_we ? en_wdata : en;
    pend_d = (pend & ~(clr_we ? clr_mask : '0)) | cond;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      en   <= '0;
      pend <= '0;
      irq  <= 1'b0;
    end else begin
      en   <= en_d;
      pend <= pend_d;
      irq  <= |(pend_d & en_d);
    end
  end

endmodule

// File: rtl/spi_seq_csr.sv
module spi_seq_csr
  import spi_csr_pkg::*;
#(
  parameter int ADDR_W          = 8,
  parameter int DATA_W          = 32,
  parameter int CMD_W           = 16,
  parameter int TX_W            = 8,
  parameter int RX_W            = 8,
  parameter int ID_W            = 8,
  parameter int CMD_DEPTH       = 16,
  parameter int TX_DEPTH        = 16,
  parameter int RX_DEPTH        = 16,
  parameter int CMD_AE          = CMD_DEPTH / 4,
  parameter int TX_AE           = TX_DEPTH / 4,
  parameter int RX_AF           = (3 * RX_DEPTH) / 4,
  parameter logic [7:0] VER_MAJOR = 8'd1,
  parameter logic [7:0] VER_MINOR = 8'd0,
  parameter logic [7:0] VER_PATCH = 8'h61
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq,
  output logic              engine_rst,
  input  logic              cmd_rd,
  output logic [CMD_W-1:0]  cmd_data,
  output logic              cmd_valid,
  input  logic              tx_rd,
  output logic [TX_W-1:0]   tx_data,
  output logic              tx_valid,
  input  logic              rx_wr,
  input  logic [RX_W-1:0]   rx_data,
  output logic              rx_ready,
  input  logic              sync_pulse,
  input  logic [ID_W-1:0]   sync_id
);

  localparam int CMD_CW = $clog2(CMD_DEPTH) + 1;
  localparam int TX_CW  = $clog2(TX_DEPTH) + 1;
  localparam int RX_CW  = $clog2(RX_DEPTH) + 1;

  csr_sel_e wsel, rsel;
  assign wsel = csr_decode(wr_addr[7:2]);
  assign rsel = csr_decode(rd_addr[7:2]);

  // soft reset register, held after power-on reset
  logic srst_q;
  always_ff @(posedge clk) begin
    if (rst)                             srst_q <= 1'b1;
    else if (wr_en && wsel == SEL_SRST)  srst_q <= wr_data[0];
  end
  assign engine_rst = srst_q;

  // queues
  logic [CMD_CW-1:0] cmd_cnt;
  logic [TX_CW-1:0]  tx_cnt;
  logic [RX_CW-1:0]  rx_cnt;
  logic              cmd_full, cmd_empty, tx_full, tx_empty, rx_full, rx_empty;
  logic [RX_W-1:0]   rx_head;
  logic              cmd_push, tx_push, rx_push, rx_pop;

  assign cmd_push = wr_en && (wsel == SEL_CMD_PUSH) && !srst_q;
  assign tx_push  = wr_en && (wsel == SEL_TX_PUSH) && !srst_q;
  assign rx_push  = rx_wr && !srst_q;
  assign rx_pop   = rd_en && (rsel == SEL_RX_POP);

  csr_fifo #(.W(CMD_W), .DEPTH(CMD_DEPTH)) u_cmd_q (
    .clk(clk), .rst(rst), .flush(srst_q),
    .push(cmd_push), .din(wr_data[CMD_W-1:0]),
    .pop(cmd_rd), .dout(cmd_data),
    .count(cmd_cnt), .full(cmd_full), .empty(cmd_empty)
  );

  csr_fifo #(.W(TX_W), .DEPTH(TX_DEPTH)) u_tx_q (
    .clk(clk), .rst(rst), .flush(srst_q),
    .push(tx_push), .din(wr_data[TX_W-1:0]),
    .pop(tx_rd), .dout(tx_data),
    .count(tx_cnt), .full(tx_full), .empty(tx_empty)
  );

  csr_fifo #(.W(RX_W), .DEPTH(RX_DEPTH)) u_rx_q (
    .clk(clk), .rst(rst), .flush(srst_q),
    .push(rx_push), .din(rx_data),
    .pop(rx_pop), .dout(rx_head),
    .count(rx_cnt), .full(rx_full), .empty(rx_empty)
  );

  assign cmd_valid = !cmd_empty;
  assign tx_valid  = !tx_empty;
  assign rx_ready  = !rx_full && !srst_q;

  // sync capture
  logic [ID_W-1:0] sync_q;
  logic            sync_evt;
  assign sync_evt = sync_pulse && !srst_q;

  always_ff @(posedge clk) begin
    if (rst)           sync_q <= '0;
    else if (sync_evt) sync_q <= sync_id;
  end

  // interrupts
  logic [IRQ_N-1:0] irq_cond, irq_en, irq_pend;

  always_comb begin
    irq_cond              = '0;
    irq_cond[IRQ_CMD_LOW] = (cmd_cnt <= CMD_CW'(CMD_AE));
    irq_cond[IRQ_TX_LOW]  = (tx_cnt <= TX_CW'(TX_AE));
    irq_cond[IRQ_RX_HIGH] = (rx_cnt >= RX_CW'(RX_AF));
    irq_cond[IRQ_SYNC]    = sync_evt;
  end

  csr_irq #(.N(IRQ_N)) u_irq (
    .clk(clk), .rst(rst),
    .en_we(wr_en && wsel == SEL_IRQ_EN), .en_wdata(wr_data[IRQ_N-1:0]),
    .clr_we(wr_en && wsel == SEL_IRQ_PEND), .clr_mask(wr_data[IRQ_N-1:0]),
    .cond(irq_cond), .en(irq_en), .pend(irq_pend), .irq(irq)
  );

  // read path
  logic [DATA_W-1:0] rd_mux;
  logic [DATA_W-1:0] rx_word;
  assign rx_word = rx_empty ? '0 : DATA_W'(rx_head);

  always_comb begin
    case (rsel)
      SEL_VERSION:  rd_mux = DATA_W'({8'h00, VER_MAJOR, VER_MINOR, VER_PATCH});
      SEL_SRST:     rd_mux = DATA_W'(srst_q);
      SEL_IRQ_EN:   rd_mux = DATA_W'(irq_en);
      SEL_IRQ_PEND: rd_mux = DATA_W'(irq_pend);
      SEL_SYNC_ID:  rd_mux = DATA_W'(sync_q);
      SEL_CMD_ROOM: rd_mux = DATA_W'(CMD_CW'(CMD_DEPTH) - cmd_cnt);
      SEL_TX_ROOM:  rd_mux = DATA_W'(TX_CW'(TX_DEPTH) - tx_cnt);
      SEL_RX_LEVEL: rd_mux = DATA_W'(rx_cnt);
      SEL_RX_POP:   rd_mux = rx_word;
      SEL_RX_PEEK:  rd_mux = rx_word;
      default:      rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
    else            rd_data <= '0;
  end

  logic unused_ok;
  assign unused_ok = ^{wr_addr[1:0], rd_addr[1:0], wr_data, cmd_full, tx_full};

endmodule

// File: rtl/spi_seq_csr_chk.sv
module spi_seq_csr_chk #(
  parameter int DATA_W   = 32,
  parameter int ID_W     = 8,
  parameter int RX_DEPTH = 16
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       rd_en,
  input logic [5:0]                 rd_word,
  input logic [DATA_W-1:0]          rd_data,
  input logic                       irq,
  input logic [3:0]                 irq_en,
  input logic [3:0]                 irq_pend,
  input logic                       engine_rst,
  input logic                       cmd_valid,
  input logic                       tx_valid,
  input logic                       sync_pulse,
  input logic [ID_W-1:0]            sync_id,
  input logic [ID_W-1:0]            sync_q,
  input logic [$clog2(RX_DEPTH):0]  rx_cnt,
  input logic                       rx_empty
);

  p_ver_major_r2: assert property (@(posedge clk) disable iff (rst)
    rd_en && rd_word == 6'h00 |=> rd_data[23:16] == 8'd1);

  p_flush_r3: assert property (@(posedge clk) disable iff (rst)
    engine_rst |=> !cmd_valid && !tx_valid);

  p_rx_bound_r6: assert property (@(posedge clk) disable iff (rst)
    rx_cnt <= ($clog2(RX_DEPTH) + 1)'(RX_DEPTH));

  p_empty_pop_zero_r8: assert property (@(posedge clk) disable iff (rst)
    rd_en && rd_word == 6'h3A && rx_empty |=> rd_data == '0 && rx_empty);

  p_sync_capture_r10: assert property (@(posedge clk) disable iff (rst)
    sync_pulse && !engine_rst |=> irq_pend[3] && sync_q == $past(sync_id));

  p_irq_level_r11: assert property (@(posedge clk) disable iff (rst)
    irq == |(irq_en & irq_pend));

  p_rd_idle_zero_r12: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> rd_data == '0);

endmodule

bind spi_seq_csr spi_seq_csr_chk #(
  .DATA_W(DATA_W), .ID_W(ID_W), .RX_DEPTH(RX_DEPTH)
) u_chk (
  .clk(clk), .rst(rst), .rd_en(rd_en), .rd_word(rd_addr[7:2]),
  .rd_data(rd_data), .irq(irq), .irq_en(irq_en), .irq_pend(irq_pend),
  .engine_rst(engine_rst), .cmd_valid(cmd_valid), .tx_valid(tx_valid),
  .sync_pulse(sync_pulse), .sync_id(sync_id), .sync_q(sync_q),
  .rx_cnt(rx_cnt), .rx_empty(rx_empty)
);

// File: tb/test_spi_seq_csr.sv
module test_spi_seq_csr;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        irq, engine_rst;
  logic        cmd_rd = 1'b0, tx_rd = 1'b0, rx_wr = 1'b0, sync_pulse = 1'b0;
  logic [15:0] cmd_data;
  logic [7:0]  tx_data, sync_id = '0, rx_data = '0;
  logic        cmd_valid, tx_valid, rx_ready;

  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  spi_seq_csr i_spi_seq_csr (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq),
    .engine_rst(engine_rst), .cmd_rd(cmd_rd), .cmd_data(cmd_data),
    .cmd_valid(cmd_valid), .tx_rd(tx_rd), .tx_data(tx_data), .tx_valid(tx_valid),
    .rx_wr(rx_wr), .rx_data(rx_data), .rx_ready(rx_ready),
    .sync_pulse(sync_pulse), .sync_id(sync_id)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic csr_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk); #1; wr_en = 1'b0;
  endtask

  task automatic csr_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; rd_addr = a;
    @(posedge clk); #1; rd_en = 1'b0; d = rd_data;
  endtask

  task automatic rx_push(input logic [7:0] d);
    @(negedge clk); rx_wr = 1'b1; rx_data = d;
    @(posedge clk); #1; rx_wr = 1'b0;
  endtask

  task automatic cmd_pop(output logic [15:0] v, output logic ok);
    @(negedge clk); v = cmd_data; ok = cmd_valid; cmd_rd = 1'b1;
    @(posedge clk); #1; cmd_rd = 1'b0;
  endtask

  task automatic tx_pop(output logic [7:0] v, output logic ok);
    @(negedge clk); v = tx_data; ok = tx_valid; tx_rd = 1'b1;
    @(posedge clk); #1; tx_rd = 1'b0;
  endtask

  task automatic sync_evt(input logic [7:0] id);
    @(negedge clk); sync_pulse = 1'b1; sync_id = id;
    @(posedge clk); #1; sync_pulse = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // {op(2): 0 write 1 read, req(4), addr(8), data(32), expect(32)}
  localparam int NV = 17;
  localparam logic [77:0] VEC [NV] = '{
    {2'd1, 4'd2,  8'h00, 32'h0, 32'h0001_0061},  // R2 version
    {2'd1, 4'd1,  8'h40, 32'h0, 32'h1},          // R1 soft reset held
    {2'd1, 4'd1,  8'h80, 32'h0, 32'h0},          // R1 enable clear
    {2'd1, 4'd4,  8'hD0, 32'h0, 32'd16},         // R4 room
    {2'd0, 4'd3,  8'hE0, 32'h1234, 32'h0},       // R3 push under reset
    {2'd1, 4'd3,  8'hD0, 32'h0, 32'd16},         // R3 dropped
    {2'd0, 4'd3,  8'h40, 32'h0, 32'h0},          // R3 release
    {2'd1, 4'd3,  8'h40, 32'h0, 32'h0},          // R3 released
    {2'd0, 4'd4,  8'hE0, 32'hABCD_1234, 32'h0},  // R4 push
    {2'd0, 4'd4,  8'hE0, 32'h5678, 32'h0},       // R4 push
    {2'd1, 4'd4,  8'hD0, 32'h0, 32'd14},         // R4 room
    {2'd0, 4'd5,  8'hE4, 32'h1FF, 32'h0},        // R5 push low byte
    {2'd1, 4'd5,  8'hD4, 32'h0, 32'd15},         // R5 room
    {2'd1, 4'd8,  8'hE8, 32'h0, 32'h0},          // R8 empty pop
    {2'd1, 4'd8,  8'hD8, 32'h0, 32'h0},          // R8 level unchanged
    {2'd1, 4'd9,  8'h84, 32'h0, 32'h3},          // R9 low-water bits
    {2'd1, 4'd12, 8'h10, 32'h0, 32'h0}           // R12 unmapped
  };

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    logic [15:0] c;
    logic [7:0]  t;
    logic        ok;

    repeat (3) @(posedge clk);
    #1; rst = 1'b0;
    check("R1 irq", {31'd0, irq}, 32'd0);
    check("R1 rd_data", rd_data, 32'd0);
    check("R3 engine_rst", {31'd0, engine_rst}, 32'd1);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][77:76] == 2'd0) csr_wr(VEC[i][71:64], VEC[i][63:32]);
      else begin
        csr_rd(VEC[i][71:64], r);
        check($sformatf("R%0d vec%0d", VEC[i][75:72], i), r, VEC[i][31:0]);
      end
    end

    // R4 ordering
    cmd_pop(c, ok); check("R4 first", {15'd0, ok, c}, {16'd1, 16'h1234});
    cmd_pop(c, ok); check("R4 second", {15'd0, ok, c}, {16'd1, 16'h5678});
    check("R4 empty", {31'd0, cmd_valid}, 32'd0);
    // R5 head
    check("R5 head", {23'd0, tx_valid, tx_data}, {23'd0, 1'b1, 8'hFF});

    // R6 receive path
    for (int i = 0; i < 12; i++) rx_push(8'h11 + 8'(i));
    csr_rd(8'hD8, r); check("R6 level", r, 32'd12);
    csr_rd(8'h84, r); check("R9 rx high", (r >> 2) & 1, 32'd1);
    csr_rd(8'hEC, r); check("R6 peek", r, 32'h11);
    csr_rd(8'hEC, r); check("R6 peek again", r, 32'h11);
    csr_rd(8'hD8, r); check("R6 peek keeps", r, 32'd12);
    csr_rd(8'hE8, r); check("R6 pop", r, 32'h11);
    csr_rd(8'hD8, r); check("R6 level after pop", r, 32'd11);
    csr_wr(8'h84, 32'h4);
    csr_rd(8'h84, r); check("R9 cleared when below", (r >> 2) & 1, 32'd0);
    // R9 level reassert: cmd queue is empty
    csr_wr(8'h84, 32'h1);
    csr_rd(8'h84, r); check("R9 reassert", r & 1, 32'd1);

    // R7 transmit overflow
    for (int i = 1; i <= 16; i++) csr_wr(8'hE4, 32'(i));
    csr_rd(8'hD4, r); check("R7 tx full", r, 32'd0);
    tx_pop(t, ok); check("R7 tx first", {24'd0, t}, 32'hFF);
    for (int i = 1; i <= 15; i++) tx_pop(t, ok);
    check("R7 tx last kept", {24'd0, t}, 32'd15);
    check("R7 tx drained", {31'd0, tx_valid}, 32'd0);

    // R7 receive overflow
    for (int i = 0; i < 5; i++) rx_push(8'h21 + 8'(i));
    check("R7 rx_ready low", {31'd0, rx_ready}, 32'd0);
    rx_push(8'h26);
    csr_rd(8'hD8, r); check("R7 rx level", r, 32'd16);
    for (int i = 0; i < 16; i++) csr_rd(8'hE8, r);
    check("R7 rx last", r, 32'h25);
    csr_rd(8'hEC, r); check("R8 empty peek", r, 32'd0);

    // R10 sync
    sync_evt(8'h5A);
    csr_rd(8'hC0, r); check("R10 id", r, 32'h5A);
    csr_rd(8'h84, r); check("R10 pending", (r >> 3) & 1, 32'd1);
    csr_rd(8'h84, r); check("R10 sticky", (r >> 3) & 1, 32'd1);
    csr_wr(8'h84, 32'h8);
    csr_rd(8'h84, r); check("R10 cleared", (r >> 3) & 1, 32'd0);

    // R11 interrupt
    check("R11 masked", {31'd0, irq}, 32'd0);
    csr_wr(8'h80, 32'h8);
    check("R11 enabled no pending", {31'd0, irq}, 32'd0);
    sync_evt(8'h33);
    check("R11 sync raises", {31'd0, irq}, 32'd1);
    csr_wr(8'h84, 32'hFF);
    check("R11 clear drops", {31'd0, irq}, 32'd0);
    csr_wr(8'h80, 32'h1);
    check("R11 cmd low", {31'd0, irq}, 32'd1);
    csr_wr(8'h80, 32'h0);
    check("R11 disabled", {31'd0, irq}, 32'd0);

    // R3 soft reset flushes
    for (int i = 0; i < 3; i++) rx_push(8'h40 + 8'(i));
    csr_wr(8'hE4, 32'h77);
    csr_wr(8'h40, 32'h1);
    @(posedge clk); #1;
    check("R3 engine_rst", {31'd0, engine_rst}, 32'd1);
    check("R3 tx flushed", {31'd0, tx_valid}, 32'd0);
    check("R3 rx_ready", {31'd0, rx_ready}, 32'd0);
    csr_rd(8'hD8, r); check("R3 rx flushed", r, 32'd0);
    rx_push(8'h99);
    csr_rd(8'hD8, r); check("R3 rx push dropped", r, 32'd0);

    finish_run();
  end

endmodule